// File: doc/BRIEF.md
# Delta-Frame Pixel Subtractor Engine

This engine builds a difference image in shared memory. Two frames of equal size are stored one after the other, starting at address 0. When the controller raises the start flag, the engine walks through every word location of the first frame. For each location it fetches the word of the first frame, then the matching word of the second frame. It subtracts them pixel by pixel and stores the result in a third region that follows the second frame. The host can then read the result region back.

A 16-bit location count sets the frame size and is captured at start. Each 32-bit word holds four 8-bit pixels. Each pixel lane is subtracted on its own, and a negative result is clamped to zero. The engine has its own request port with separate read and write strobes, an 18-bit address and 32-bit write data. It holds each request until the shared memory returns its access-done pulse. When all locations are written, the completion flag rises. It stays high until the controller drops the start flag, and the engine can then be started again.

Top module: `dfrm_sub_engine`

## Requirements
- R1: During and right after reset, done_o, mem_rd_o and mem_wr_o are all low.
- R2: After start_i is seen high with a nonzero range, the first access is a read of address 0.
- R3: For location index i (0 to N-1, where N is the captured range), the engine reads address i, then reads address N+i, then writes address 2N+i. The indices are handled in increasing order.
- R4: At most one strobe is high at any time. A raised strobe stays high, with the same address and write data, until mem_done_i is sampled high.
- R5: Each 8-bit lane of the written word (bits 8k+7:8k, k=0..3) is computed only from lane k of the two read words. There is no borrow from one lane into another.
- R6: A lane where the first-frame pixel is below the second-frame pixel writes 0. Otherwise it writes the plain difference.
- R7: Exactly N writes happen in a run, and done_o rises only after the last write has completed.
- R8: done_o stays high while start_i stays high. It is low one cycle after start_i is seen low, and a new run can then be started.
- R9: With a range of 0, done_o is high in the cycle after start_i is sampled, and no strobe is raised.
- R10: Changes to range_i after start do not affect the run in progress. The value sampled with start is used throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, held high until done is seen |
| range_i | input | 16 | Number of word locations per frame |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 18 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_done_i |
| mem_done_i | input | 1 | Access-done pulse from memory |
| done_o | output | 1 | Run complete |

## Verification
A corrupted location counter or captured range shows up at the port on the next access. The address leaves the expected i, N+i, 2N+i pattern, or the run ends with too few or too many writes. A wrong state transition makes a strobe drop, or the access kind change, before mem_done_i arrives. It can also leave done_o high while an access is pending, which is seen within one cycle. A fault in the lane datapath is seen only at the write that follows, so the data patterns include borrow, equal, and near-zero pixel pairs.

// File: rtl/dfrm_pkg.sv
package dfrm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_WR,
      ST_FIN
   } dfrm_state_e;

   typedef enum logic [1:0] {
      RG_SRC_A,
      RG_SRC_B,
      RG_DST
   } dfrm_region_e;
endpackage

// File: rtl/dfrm_lane_sub.sv
module dfrm_lane_sub #(
   parameter int PIX_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic [PIX_W-1:0] a_i,
   input  logic [PIX_W-1:0] b_i,
   output logic [PIX_W-1:0] d_o
);
   initial begin
      if (PIX_W < 1) $error("PIX_W must be positive");
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb d_o = (a_i >= b_i) ? (a_i - b_i) : '0;
      end else begin : g_wrap
         always_comb d_o = a_i - b_i;
      end
   endgenerate
endmodule

// File: rtl/dfrm_addr_gen.sv
module dfrm_addr_gen
   import dfrm_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int CNT_W  = 16
) (
   input  dfrm_region_e      region_i,
   input  logic [CNT_W-1:0]  range_i,
   input  logic [CNT_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int PAD_W = ADDR_W - CNT_W;

   initial begin
      if (ADDR_W < CNT_W + 2) $error("ADDR_W must cover three frames");
   end

   logic [ADDR_W-1:0] rng_w, idx_w, base_w;

   always_comb begin
      rng_w = {{PAD_W{1'b0}}, range_i};
      idx_w = {{PAD_W{1'b0}}, idx_i};
      unique case (region_i)
         RG_SRC_A: base_w = '0;
         RG_SRC_B: base_w = rng_w;
         RG_DST:   base_w = rng_w << 1;
         default:  base_w = '0;
      endcase
      addr_o = base_w + idx_w;
   end
endmodule

// File: rtl/dfrm_sub_engine.sv
module dfrm_sub_engine
   import dfrm_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 32,
   parameter int PIX_W    = 8,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  range_i,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_done_i,
   output logic              done_o
);
   localparam int LANES = DATA_W / PIX_W;

   initial begin
      if (DATA_W % PIX_W != 0) $error("DATA_W must be a multiple of PIX_W");
      if (ADDR_W < CNT_W + 2)  $error("ADDR_W too small for three frames");
   end

   dfrm_state_e       state_q, state_d;
   logic [CNT_W-1:0]  range_q, idx_q;
   logic [DATA_W-1:0] pix_a_q, pix_b_q, diff_w;
   dfrm_region_e      region_w;
   logic              last_w;

   assign last_w = (idx_q == range_q - 1'b1);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i) state_d = (range_i == '0) ? ST_FIN : ST_RD_A;
         ST_RD_A: if (mem_done_i) state_d = ST_RD_B;
         ST_RD_B: if (mem_done_i) state_d = ST_WR;
         ST_WR:   if (mem_done_i) state_d = last_w ? ST_FIN : ST_RD_A;
         ST_FIN:  if (!start_i) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         range_q <= '0;
         idx_q   <= '0;
         pix_a_q <= '0;
         pix_b_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            range_q <= range_i;
            idx_q   <= '0;
         end
         if (state_q == ST_RD_A && mem_done_i) pix_a_q <= mem_rdata_i;
         if (state_q == ST_RD_B && mem_done_i) pix_b_q <= mem_rdata_i;
         if (state_q == ST_WR && mem_done_i && !last_w) idx_q <= idx_q + 1'b1;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_RD_B: region_w = RG_SRC_B;
         ST_WR:   region_w = RG_DST;
         default: region_w = RG_SRC_A;
      endcase
   end

   dfrm_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
      .region_i (region_w),
      .range_i  (range_q),
      .idx_i    (idx_q),
      .addr_o   (mem_addr_o)
   );

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         dfrm_lane_sub #(.PIX_W(PIX_W), .SATURATE(SATURATE)) u_lane (
            .a_i (pix_a_q[k*PIX_W +: PIX_W]),
            .b_i (pix_b_q[k*PIX_W +: PIX_W]),
            .d_o (diff_w[k*PIX_W +: PIX_W])
         );
      end
   endgenerate

   assign mem_rd_o    = (state_q == ST_RD_A) || (state_q == ST_RD_B);
   assign mem_wr_o    = (state_q == ST_WR);
   assign mem_wdata_o = diff_w;
   assign done_o      = (state_q == ST_FIN);

   // Assertions
   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));
   p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && !mem_done_i) |=> (mem_rd_o && $stable(mem_addr_o)));
   p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && !mem_done_i) |=> (mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && start_i) |=> done_o);
   p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);
   p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!mem_rd_o && !mem_wr_o));
   p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_o && !mem_wr_o && !done_o && start_i && range_i != '0) |=> (mem_rd_o && mem_addr_o == '0));
   p_zero_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_o && !mem_wr_o && !done_o && start_i && range_i == '0) |=> done_o);
endmodule

// File: tb/dfrm_sub_engine_test.sv
`timescale 1ns/1ps
module dfrm_sub_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] range_i = '0;
   logic        mem_rd_o, mem_wr_o, done_o;
   logic [17:0] mem_addr_o;
   logic [31:0] mem_wdata_o;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_done_i = 1'b0;

   always #2 clk = ~clk;

   dfrm_sub_engine uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .range_i(range_i),
      .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_done_i(mem_done_i), .done_o(done_o)
   );

   typedef struct {
      bit          wr;
      logic [17:0] addr;
      logic [31:0] data;
   } acc_t;

   acc_t        exp_q[$];
   logic [31:0] mem [0:63];
   int          lat = 0;
   int          lat_cnt = 0;
   int          checks = 0, errors = 0;
   int          m_checks = 0, m_errors = 0;
   int          wr_seen = 0;

   // memory model: responds after lat cycles with a one-cycle done pulse
   always @(negedge clk) begin
      if (mem_done_i) mem_done_i = 1'b0;
      else if (rst_n && (mem_rd_o || mem_wr_o)) begin
         if (lat_cnt >= lat) begin
            lat_cnt = 0;
            mem_done_i = 1'b1;
            if (mem_wr_o) mem[mem_addr_o[5:0]] = mem_wdata_o;
            else          mem_rdata_i = mem[mem_addr_o[5:0]];
         end else lat_cnt++;
      end
   end

   // monitor: compares each completed access against the scoreboard
   logic        p_rd = 0, p_wr = 0, p_dn = 0;
   logic [17:0] p_addr = '0;
   logic [31:0] p_wd = '0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if ((p_rd || p_wr) && !p_dn) begin // R4 hold check
            m_checks++;
            if (p_rd != mem_rd_o || p_wr != mem_wr_o || p_addr != mem_addr_o || (p_wr && p_wd != mem_wdata_o)) begin
               m_errors++;
               $display("FAIL R4 request changed before done: rd=%0b wr=%0b addr=%0d exp rd=%0b wr=%0b addr=%0d",
                        mem_rd_o, mem_wr_o, mem_addr_o, p_rd, p_wr, p_addr);
            end
         end
         if (mem_rd_o && mem_wr_o) begin
            m_errors++; m_checks++;
            $display("FAIL R4 both strobes high: rd=1 wr=1 exp one");
         end
         if (done_o && exp_q.size() != 0) begin
            m_errors++; m_checks++;
            $display("FAIL R7 done with %0d accesses pending, exp 0", exp_q.size());
         end
         if ((mem_rd_o || mem_wr_o) && mem_done_i) begin
            m_checks++;
            if (exp_q.size() == 0) begin
               m_errors++;
               $display("FAIL R9 unexpected access wr=%0b addr=%0d, exp none", mem_wr_o, mem_addr_o);
            end else begin
               acc_t e;
               e = exp_q.pop_front();
               if (e.wr != mem_wr_o || e.addr != mem_addr_o) begin
                  m_errors++;
                  $display("FAIL R3 access wr=%0b addr=%0d, exp wr=%0b addr=%0d",
                           mem_wr_o, mem_addr_o, e.wr, e.addr);
               end else if (e.wr && e.data != mem_wdata_o) begin
                  m_errors++;
                  $display("FAIL R5/R6 write data %h, exp %h at addr %0d", mem_wdata_o, e.data, e.addr);
               end
               if (mem_wr_o) wr_seen++;
            end
         end
      end
      p_rd = mem_rd_o; p_wr = mem_wr_o; p_dn = mem_done_i;
      p_addr = mem_addr_o; p_wd = mem_wdata_o;
   end

   function automatic logic [31:0] pat(int i, int s);
      return {8'(i*37 + s), 8'(s*11 + i), 8'(255 - i*3), 8'(i + s)};
   endfunction

   function automatic logic [31:0] sat_sub(logic [31:0] a, logic [31:0] b);
      logic [31:0] r;
      for (int k = 0; k < 4; k++)
         r[k*8 +: 8] = (a[k*8 +: 8] >= b[k*8 +: 8]) ? a[k*8 +: 8] - b[k*8 +: 8] : 8'd0;
      return r;
   endfunction

   task automatic check(bit ok, string req, string msg, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, msg, act, exp);
      end
   endtask

   task automatic run(int n, int seed, int l, bit special);
      acc_t e;
      lat = l;
      for (int a = 0; a < 64; a++) mem[a] = 32'hDEAD0000 + a;
      for (int i = 0; i < n; i++) begin
         mem[i]     = pat(i, seed);
         mem[n + i] = pat(i + 3, seed * 5);
      end
      if (special) begin
         // R5 R6: borrow lane, equal lane, max-minus-one lane
         mem[0] = 32'h10_00_FF_05; mem[n] = 32'h0F_01_01_05;
      end
      wr_seen = 0;
      for (int i = 0; i < n; i++) begin
         e.wr = 0; e.addr = 18'(i);     e.data = '0; exp_q.push_back(e);
         e.wr = 0; e.addr = 18'(n + i); exp_q.push_back(e);
         e.wr = 1; e.addr = 18'(2*n + i); e.data = sat_sub(mem[i], mem[n + i]);
         exp_q.push_back(e);
      end
      @(negedge clk);
      start_i = 1'b1; range_i = 16'(n);
      @(negedge clk);
      range_i = 16'(n + 5); // R10: ignored after start
      for (int c = 0; c < 2000 && !done_o; c++) @(negedge clk);
      check(done_o, "R7", "done after run", done_o, 1);
      check(exp_q.size() == 0, "R3", "accesses left in scoreboard", exp_q.size(), 0);
      check(wr_seen == n, "R7", "write count", wr_seen, n);
      if (special)
         check(mem[2*n] == 32'h01_00_FE_00, "R6", "saturated lanes", mem[2*n], 32'h01_00_FE_00);
      repeat (3) @(negedge clk);
      check(done_o, "R8", "done held while start high", done_o, 1);
      start_i = 1'b0;
      @(negedge clk);
      check(!done_o, "R8", "done cleared after start low", done_o, 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!done_o && !mem_rd_o && !mem_wr_o, "R1", "reset outputs quiet",
            {done_o, mem_rd_o, mem_wr_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done_o && !mem_rd_o && !mem_wr_o, "R1", "idle after reset",
            {done_o, mem_rd_o, mem_wr_o}, 0);
      // R2 first access read of 0 (scoreboard), R5/R6 lane data
      run(4, 1, 0, 1'b1);
      run(6, 9, 3, 1'b0);  // slow memory, R4 hold
      run(1, 22, 1, 1'b1); // restart with single location, R8
      // R9 zero range
      @(negedge clk);
      start_i = 1'b1; range_i = 16'd0;
      @(negedge clk);
      check(done_o, "R9", "done right after zero-range start", done_o, 1);
      check(!mem_rd_o && !mem_wr_o, "R9", "no strobe on zero range", {mem_rd_o, mem_wr_o}, 0);
      repeat (2) @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      check(!done_o, "R8", "done cleared after zero-range run", done_o, 0);
      run(8, 40, 2, 1'b0);
      repeat (2) @(negedge clk);
      errors += m_errors; checks += m_checks;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors += m_errors + 1; checks += m_checks + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule